// File: doc/BRIEF.md
# Tick-Counted Pulse-Width Modulator Channel

This block produces one pulse-width-modulated output from two programmed tick counts. A period length (the span register) and a high-time length (the mark register) are written over a simple word-indexed register bus. The counter advances only on cycles where an external divider asserts a clock enable, so one tick is one enabled cycle. A control bit picks the waveform shape. In mark-space shape the high ticks come first and form one contiguous pulse at the start of every period. In balanced shape the same number of high ticks is spread across the period by an accumulator.

Software disables the channel, programs the span and mark counts, and then enables it again. New counts written while the channel runs are held in shadow registers and are copied into the active set only at a period boundary. Four sticky event flags report period ends, saturated programming, a zero span and reloads. Each flag is cleared by writing a one to it. A sequencer with three states drives the output. `ST_OFF` holds the output low while the channel is disabled. `ST_RUN` counts ticks through the active period. `ST_HALT` parks the output low while the span is zero.

The sequencer moves between states as follows:
- From any state, a cleared enable bit moves it to `ST_OFF`.
- `ST_OFF` goes to `ST_RUN` on enable with a nonzero span, loading the counts. With a zero span it goes to `ST_HALT` instead.
- `ST_RUN` stays in `ST_RUN` at a period end, reloading the counts. If the span has been set to zero, it goes to `ST_HALT` at the period end instead.
- `ST_HALT` goes to `ST_RUN` on the first tick that finds a nonzero span, loading the counts.

Top module: `rdpwm_channel`

## Requirements
- R1: The register word indices are control = 0, status = 1, span = 4 and mark = 5. Control bit 0 is enable and control bit 7 selects mark-space shape. Reading control returns only those two bits. The span and mark registers read back as written. Any other index reads 0.
- R2: Clearing the enable bit drives the output low from the next cycle and holds the tick counter at zero. Enabling again starts a fresh period at tick 0.
- R3: In mark-space shape with span S and mark M (0 < M < S), the output is high at tick positions 0..M-1 of every S-tick period and low for the rest. For example, span 8 and mark 4 gives 50%, and mark 2 gives 25%.
- R4: When mark is greater than or equal to span, the output stays high for the whole period, and status bit 1 sets when those counts are loaded. A mark of 0 keeps the output low.
- R5: Span 2 with mark 1 makes the output alternate on every tick, in both shapes.
- R6: In balanced shape, an accumulator starts at 0 each period and the mark is added to it on each tick. On a tick where the sum reaches the span, the output is high and the span is subtracted. For span 8, mark 2 the output is high at positions 3 and 7. For span 8, mark 3 it is high at positions 2, 5 and 7.
- R7: Span and mark writes made while running take effect only at the next period boundary. The current period finishes with the old counts.
- R8: The tick counter advances only on cycles where the tick enable input is high.
- R9: The status flags are: bit 0 = period ended, bit 1 = saturated mark loaded, bit 2 = zero span written, bit 3 = counts loaded. Writing a 1 to a bit clears that flag. Writing a 0 leaves it unchanged. A flag event in the same cycle as a clear wins.
- R10: Writing span 0 sets status bit 2. The channel finishes its current period and then holds the output low. Enabling with span 0 also holds it low. The first tick that finds a nonzero span starts a new period at tick 0.
- R11: After reset, the output is low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Clock enable from the divider; one high cycle is one tick |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for the indexed register (combinational) |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench checks the saturated and empty mark settings. A comparator with an off-by-one error would drop one high tick from a saturated period or leak a high tick when the mark is 0. It rewrites the mark in the middle of a period: a design that loads new counts immediately would truncate that period. It gates the tick enable to show that the counter holds between ticks, and it parks the channel on a zero span and revives it. An unguarded design would divide by a wrapped span of all ones or stay parked. The write-one-to-clear tests write zero and single-bit masks, which catch a design that clears on any write or clears the wrong flag.

// File: rtl/rdpwm_pkg.sv
package rdpwm_pkg;
    localparam logic [2:0] IDX_CTRL  = 3'd0;
    localparam logic [2:0] IDX_STAT  = 3'd1;
    localparam logic [2:0] IDX_SPAN  = 3'd4;
    localparam logic [2:0] IDX_MARK  = 3'd5;

    localparam int unsigned CTRL_EN_BIT = 0;
    localparam int unsigned CTRL_MS_BIT = 7;

    localparam int unsigned FLG_PERIOD = 0;
    localparam int unsigned FLG_SAT    = 1;
    localparam int unsigned FLG_ZERO   = 2;
    localparam int unsigned FLG_LOAD   = 3;
    localparam int unsigned FLG_N      = 4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rdpwm_regs.sv
module rdpwm_regs
    import rdpwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [2:0]   idx,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         en,
    output logic         ms,
    output logic [W-1:0] shd_span,
    output logic [W-1:0] shd_mark,
    input  logic         ev_period,
    input  logic         ev_sat,
    input  logic         ev_load
);
    logic             en_q, ms_q;
    logic [W-1:0]     span_q, mark_q;
    logic [FLG_N-1:0] flg_q, flg_set, flg_clr;
    logic             wr_ctrl, wr_stat, wr_span, wr_mark, zero_wr;

    assign wr_ctrl = we && (idx == IDX_CTRL);
    assign wr_stat = we && (idx == IDX_STAT);
    assign wr_span = we && (idx == IDX_SPAN);
    assign wr_mark = we && (idx == IDX_MARK);
    assign zero_wr = wr_span && (wdata == '0);

    always_comb begin
        flg_set             = '0;
        flg_set[FLG_PERIOD] = ev_period;
        flg_set[FLG_SAT]    = ev_sat;
        flg_set[FLG_ZERO]   = zero_wr;
        flg_set[FLG_LOAD]   = ev_load;
        flg_clr             = wr_stat ? wdata[FLG_N-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ms_q   <= 1'b0;
            span_q <= '0;
            mark_q <= '0;
            flg_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= wdata[CTRL_EN_BIT];
                ms_q <= wdata[CTRL_MS_BIT];
            end
            if (wr_span) span_q <= wdata;
            if (wr_mark) mark_q <= wdata;
            flg_q <= (flg_q & ~flg_clr) | flg_set;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (idx)
            IDX_CTRL: begin
                rdata[CTRL_EN_BIT] = en_q;
                rdata[CTRL_MS_BIT] = ms_q;
            end
            IDX_STAT: rdata[FLG_N-1:0] = flg_q;
            IDX_SPAN: rdata = span_q;
            IDX_MARK: rdata = mark_q;
            default:  rdata = '0;
        endcase
    end

    assign en       = en_q;
    assign ms       = ms_q;
    assign shd_span = span_q;
    assign shd_mark = mark_q;

    // R10: a zero span write raises the zero flag
    a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> flg_q[FLG_ZERO]);

    // R9: flags do not move without an event or a clear write
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && (flg_set == '0)) |=> $stable(flg_q));

    // R9: a clear write with no event leaves every written-one bit clear
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (flg_set == '0)) |=> ((flg_q & $past(wdata[FLG_N-1:0])) == '0));
endmodule

// File: rtl/rdpwm_seq.sv
module rdpwm_seq
    import rdpwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         ms,
    input  logic [W-1:0] shd_span,
    input  logic [W-1:0] shd_mark,
    output logic         pwm_out,
    output logic         ev_period,
    output logic         ev_sat,
    output logic         ev_load
);
    seq_state_e   st_q, st_d;
    logic [W-1:0] cnt_q, act_span_q, act_mark_q, acc_q;
    logic [W:0]   acc_sum;
    logic [W-1:0] acc_diff, acc_nxt;
    logic         last, load, shd_zero, sat, hit;

    assign shd_zero = (shd_span == '0);
    assign last     = (cnt_q == act_span_q - 1'b1);
    assign sat      = (act_mark_q >= act_span_q);
    assign acc_sum  = {1'b0, acc_q} + {1'b0, act_mark_q};
    assign hit      = (acc_sum >= {1'b0, act_span_q});
    assign acc_diff = acc_sum[W-1:0] - act_span_q;
    assign acc_nxt  = sat ? acc_q : (hit ? acc_diff : acc_sum[W-1:0]);

    always_comb begin
        st_d      = st_q;
        load      = 1'b0;
        ev_period = 1'b0;
        if (!en) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    if (shd_zero) st_d = ST_HALT;
                    else begin
                        st_d = ST_RUN;
                        load = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (tick && last) begin
                        ev_period = 1'b1;
                        if (shd_zero) st_d = ST_HALT;
                        else load = 1'b1;
                    end
                end
                ST_HALT: begin
                    if (tick && !shd_zero) begin
                        st_d = ST_RUN;
                        load = 1'b1;
                    end
                end
                default: st_d = ST_OFF;
            endcase
        end
    end

    assign ev_load = load;
    assign ev_sat  = load && (shd_mark >= shd_span);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            acc_q      <= '0;
            act_span_q <= '0;
            act_mark_q <= '0;
        end else if (load) begin
            act_span_q <= shd_span;
            act_mark_q <= shd_mark;
            cnt_q      <= '0;
            acc_q      <= '0;
        end else if (st_q == ST_RUN && en && tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
            acc_q <= last ? '0 : acc_nxt;
        end else if (st_q != ST_RUN || !en) begin
            cnt_q <= '0;
            acc_q <= '0;
        end
    end

    always_comb begin
        pwm_out = 1'b0;
        if (st_q == ST_RUN) begin
            if (ms) pwm_out = (cnt_q < act_mark_q);
            else    pwm_out = sat || hit;
        end
    end

    // R2: disabling forces the output low and the counter to zero
    a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_out && cnt_q == '0));

    // R3: the running counter never leaves the active period
    a_r3_cnt_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cnt_q < act_span_q));

    // R8: without a tick the counter holds
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && en && !tick) |=> $stable(cnt_q));

    // R7: active counts change only at a period boundary
    a_r7_no_mid_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && en && !(tick && last)) |=>
            ($stable(act_span_q) && $stable(act_mark_q)));
endmodule

// File: rtl/rdpwm_channel.sv
module rdpwm_channel #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         reg_we,
    input  logic [2:0]   reg_idx,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         pwm_out
);
    logic         en, ms, ev_period, ev_sat, ev_load;
    logic [W-1:0] shd_span, shd_mark;

    rdpwm_regs #(.W(W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .idx       (reg_idx),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .en        (en),
        .ms        (ms),
        .shd_span  (shd_span),
        .shd_mark  (shd_mark),
        .ev_period (ev_period),
        .ev_sat    (ev_sat),
        .ev_load   (ev_load)
    );

    rdpwm_seq #(.W(W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .en        (en),
        .ms        (ms),
        .shd_span  (shd_span),
        .shd_mark  (shd_mark),
        .pwm_out   (pwm_out),
        .ev_period (ev_period),
        .ev_sat    (ev_sat),
        .ev_load   (ev_load)
    );
endmodule

// File: tb/rdpwm_channel_tb_top.sv
`timescale 1ns/1ps
module rdpwm_channel_tb_top;
    localparam int W = 16;
    localparam logic [2:0] I_CTRL = 3'd0;
    localparam logic [2:0] I_STAT = 3'd1;
    localparam logic [2:0] I_SPAN = 3'd4;
    localparam logic [2:0] I_MARK = 3'd5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b1;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_idx = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         pwm_out;

    int n_chk = 0;
    int n_err = 0;

    rdpwm_channel #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] idx, input int val);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = W'(val);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] idx, output int val);
        @(negedge clk);
        reg_idx = idx;
        #1 val = int'(reg_rdata);
    endtask

    function automatic bit model(int k, int span, int mark, bit ms);
        int pos = k % span;
        int acc = 0;
        bit hi = 1'b0;
        if (ms) return pos < mark;
        if (mark >= span) return 1'b1;
        for (int i = 0; i <= pos; i++) begin
            hi  = (acc + mark >= span);
            acc = hi ? acc + mark - span : acc + mark;
        end
        return hi;
    endfunction

    task automatic sample_cmp(input string req, input int span, input int mark, input bit ms, input int n);
        int bad = 0, hi = 0, ehi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out !== model(k, span, mark, ms)) bad++;
            hi  += int'(pwm_out);
            ehi += int'(model(k, span, mark, ms));
        end
        check_eq(req, $sformatf("pattern mismatches span=%0d mark=%0d ms=%0d", span, mark, ms), bad, 0);
        check_eq(req, "high tick count", hi, ehi);
    endtask

    task automatic run_case(input string req, input int span, input int mark, input bit ms, input int n);
        bus_wr(I_CTRL, 0);
        bus_wr(I_SPAN, span);
        bus_wr(I_MARK, mark);
        bus_wr(I_CTRL, ms ? 'h81 : 'h01);
        sample_cmp(req, span, mark, ms, n);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hi += int'(pwm_out);
        end
    endtask

    task automatic t_reset();
        int v;
        check_eq("R11", "output after reset", pwm_out, 0);
        bus_rd(I_CTRL, v); check_eq("R11", "control after reset", v, 0);
        bus_rd(I_STAT, v); check_eq("R11", "status after reset", v, 0);
        bus_rd(I_SPAN, v); check_eq("R11", "span after reset", v, 0);
        bus_rd(I_MARK, v); check_eq("R11", "mark after reset", v, 0);
    endtask

    task automatic t_regmap();
        int v;
        bus_wr(I_CTRL, 'hFFFF);
        bus_rd(I_CTRL, v); check_eq("R1", "control readback", v, 'h81);
        bus_wr(I_SPAN, 'h1234);
        bus_wr(I_MARK, 'h0055);
        bus_rd(I_SPAN, v); check_eq("R1", "span readback", v, 'h1234);
        bus_rd(I_MARK, v); check_eq("R1", "mark readback", v, 'h0055);
        for (int i = 2; i < 8; i++) begin
            if (i == 4 || i == 5) continue;
            bus_rd(3'(i), v); check_eq("R1", $sformatf("unused index %0d", i), v, 0);
        end
        bus_wr(I_CTRL, 0);
    endtask

    task automatic t_mark_space();
        run_case("R3", 8, 4, 1'b1, 16);
        run_case("R3", 8, 2, 1'b1, 16);
    endtask

    task automatic t_saturate();
        int v;
        bus_wr(I_CTRL, 0);
        bus_wr(I_STAT, 'hF);
        run_case("R4", 8, 10, 1'b1, 16);
        bus_rd(I_STAT, v); check_eq("R4", "saturated flag bit1", (v >> 1) & 1, 1);
        run_case("R4", 8, 0, 1'b1, 16);
        run_case("R4", 8, 8, 1'b0, 16);
    endtask

    task automatic t_fast();
        run_case("R5", 2, 1, 1'b1, 10);
        run_case("R5", 2, 1, 1'b0, 10);
    endtask

    task automatic t_balanced();
        run_case("R6", 8, 2, 1'b0, 16);
        run_case("R6", 8, 3, 1'b0, 16);
    endtask

    task automatic t_defer();
        int bad = 0;
        bit e;
        bus_wr(I_CTRL, 0);
        bus_wr(I_SPAN, 8);
        bus_wr(I_MARK, 4);
        bus_wr(I_CTRL, 'h81);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            reg_we = 1'b0;
            e = (k < 8) ? ((k % 8) < 4) : ((k % 8) < 6);
            if (pwm_out !== e) bad++;
            if (k == 2) begin
                reg_we = 1'b1; reg_idx = I_MARK; reg_wdata = W'(6);
            end
        end
        check_eq("R7", "mid-period mark write deferred", bad, 0);
    endtask

    task automatic t_tick_gate();
        int bad = 0, hi = 0, c = 0;
        bus_wr(I_CTRL, 0);
        tick_en = 1'b0;
        bus_wr(I_SPAN, 4);
        bus_wr(I_MARK, 1);
        bus_wr(I_CTRL, 'h81);
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (pwm_out !== (c == 0)) bad++;
            hi += int'(pwm_out);
            tick_en = ((k % 4) == 3);
            if (tick_en) c = (c + 1) % 4;
        end
        tick_en = 1'b1;
        check_eq("R8", "gated tick pattern mismatches", bad, 0);
        check_eq("R8", "gated high cycles", hi, 8);
    endtask

    task automatic t_disable();
        int hi;
        run_case("R2", 8, 4, 1'b1, 8);
        repeat (3) @(negedge clk);
        bus_wr(I_CTRL, 0);
        count_high(10, hi);
        check_eq("R2", "high cycles while disabled", hi, 0);
        bus_wr(I_CTRL, 'h81);
        sample_cmp("R2", 8, 4, 1'b1, 8);
    endtask

    task automatic t_status();
        int v;
        bus_wr(I_CTRL, 0);
        bus_wr(I_STAT, 'hF);
        bus_rd(I_STAT, v); check_eq("R9", "status after clear-all", v, 0);
        bus_wr(I_SPAN, 8);
        bus_wr(I_MARK, 10);
        bus_wr(I_CTRL, 1);
        repeat (12) @(negedge clk);
        bus_wr(I_CTRL, 0);
        bus_rd(I_STAT, v); check_eq("R9", "status after run", v, 'hB);
        bus_wr(I_STAT, 0);
        bus_rd(I_STAT, v); check_eq("R9", "status after writing zeros", v, 'hB);
        bus_wr(I_STAT, 'h2);
        bus_rd(I_STAT, v); check_eq("R9", "status after clearing bit1", v, 'h9);
        bus_wr(I_STAT, 'hF);
        bus_rd(I_STAT, v); check_eq("R9", "status after 0x0F", v, 0);
    endtask

    task automatic t_zero_span();
        int v, hi;
        bus_wr(I_CTRL, 0);
        bus_wr(I_STAT, 'hF);
        run_case("R10", 4, 2, 1'b1, 8);
        bus_wr(I_SPAN, 0);
        bus_rd(I_STAT, v); check_eq("R10", "zero span flag bit2", (v >> 2) & 1, 1);
        count_high(6, hi);
        count_high(6, hi);
        check_eq("R10", "high cycles while parked", hi, 0);
        bus_wr(I_SPAN, 4);
        sample_cmp("R10", 4, 2, 1'b1, 8);
        bus_wr(I_CTRL, 0);
        bus_wr(I_SPAN, 0);
        bus_wr(I_CTRL, 'h81);
        count_high(8, hi);
        check_eq("R10", "high cycles enabled with zero span", hi, 0);
        bus_wr(I_CTRL, 0);
    endtask

    initial begin
        #1600000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_mark_space();
        t_saturate();
        t_fast();
        t_balanced();
        t_defer();
        t_tick_gate();
        t_disable();
        t_status();
        t_zero_span();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule